// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic unit built from one 1-bit cell repeated across the operand width, 32 bits by default. Two operands and a 4-bit operation code come in. A result word and two flags go out: one marks an all-zero result and one marks signed overflow. It serves as the execute-stage arithmetic unit of a simple integer datapath. It performs bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than compare.

Each cell holds a full adder and a small output multiplexer. The carry ripples from the least significant cell to the most significant one. Subtraction uses one negate line for two jobs. That line makes every cell take the inverted B bit, and it also acts as the carry into the lowest cell, so the adder chain forms A + ~B + 1.

The compare reuses the same subtraction. The sign bit that the top cell's adder produces is routed back into the compare input of the bottom cell. The compare inputs of all other cells are tied low. No overflow correction is applied to that sign.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 4'b0000 gives result = A AND B, bit by bit.
- R2: Operation code 4'b0001 gives result = A OR B, bit by bit.
- R3: Operation code 4'b0010 gives result = (A + B) modulo 2^32.
- R4: Operation code 4'b0110 gives result = (A - B) modulo 2^32.
- R5: Operation code 4'b0111 gives bit 0 equal to bit 31 of (A - B) modulo 2^32, taken as a raw sign without overflow correction, and bits 31..1 equal to 0. For example, A = 0x7FFFFFFF and B = 0xFFFFFFFF give 0x00000001.
- R6: The zero flag is 1 exactly when all result bits are 0, under every operation code.
- R7: For add and subtract, the overflow flag is 1 exactly when the signed two's-complement result falls outside [-2^31, 2^31-1].
- R8: The overflow flag is 0 when adding operands whose sign bits differ, and when subtracting operands whose sign bits match.
- R9: The overflow flag is 0 for the AND, OR and set-on-less-than codes.
- R10: Every other operation code gives an all-zero result and an overflow flag of 0, so the zero flag reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand (A) |
| opb_i | input | 32 | Second operand (B) |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The assertions inside the RTL check these rules whenever the inputs settle:
- the add and subtract sums match a function-computed sum;
- the upper compare bits stay zero;
- the overflow flag stays low for logical, compare and unused codes and for the two sign cases that cannot overflow;
- unused codes give an all-zero result.

Only the bench scenarios can show that the AND, OR and compare results are correct value for value. They also show that the overflow flag actually rises at the signed boundaries, such as 0x7FFFFFFF + 1 and 0x80000000 - 1. Finally, they confirm that the compare reports the raw sign when the subtraction wraps.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_AND = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT = 4'b0111;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } cell_sel_e;

  typedef struct packed {
    logic      valid;
    logic      b_neg;
    logic      arith;
    cell_sel_e sel;
  } alu_ctrl_t;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctrl_t       ctrl_o
);

  always_comb begin
    ctrl_o = '{valid: 1'b0, b_neg: 1'b0, arith: 1'b0, sel: SEL_AND};
    case (op_i)
      OP_AND: ctrl_o = '{valid: 1'b1, b_neg: 1'b0, arith: 1'b0, sel: SEL_AND};
      OP_OR:  ctrl_o = '{valid: 1'b1, b_neg: 1'b0, arith: 1'b0, sel: SEL_OR};
      OP_ADD: ctrl_o = '{valid: 1'b1, b_neg: 1'b0, arith: 1'b1, sel: SEL_SUM};
      OP_SUB: ctrl_o = '{valid: 1'b1, b_neg: 1'b1, arith: 1'b1, sel: SEL_SUM};
      OP_SLT: ctrl_o = '{valid: 1'b1, b_neg: 1'b1, arith: 1'b0, sel: SEL_LESS};
      default: ctrl_o = '{valid: 1'b0, b_neg: 1'b0, arith: 1'b0, sel: SEL_AND};
    endcase
  end

endmodule

// File: rtl/alu_cell.sv
module alu_cell
  import alu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      b_neg_i,
  input  logic      cin_i,
  input  logic      less_i,
  input  cell_sel_e sel_i,
  output logic      res_o,
  output logic      sum_o,
  output logic      cout_o
);

  logic b_eff;

  assign b_eff  = b_i ^ b_neg_i;
  assign sum_o  = fa_sum(a_i, b_eff, cin_i);
  assign cout_o = fa_carry(a_i, b_eff, cin_i);

  always_comb begin
    case (sel_i)
      SEL_AND:  res_o = a_i & b_i;
      SEL_OR:   res_o = a_i | b_i;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH:0]   carry;
  logic [MSB:0]     cell_res;
  logic [MSB:0]     cell_sum;
  logic [MSB:0]     less_vec;
  logic             set_w;
  logic             carry_into_msb;
  logic             carry_out_msb;

  function automatic logic [MSB:0] sum_ref(input logic [MSB:0] a, input logic [MSB:0] b,
                                          input logic neg);
    return neg ? (a - b) : (a + b);
  endfunction

  alu_op_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign carry[0] = ctrl.b_neg;
  assign set_w    = cell_sum[MSB];
  assign less_vec = {{(WIDTH-1){1'b0}}, set_w};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    alu_cell u_cell (
      .a_i     (opa_i[i]),
      .b_i     (opb_i[i]),
      .b_neg_i (ctrl.b_neg),
      .cin_i   (carry[i]),
      .less_i  (less_vec[i]),
      .sel_i   (ctrl.sel),
      .res_o   (cell_res[i]),
      .sum_o   (cell_sum[i]),
      .cout_o  (carry[i+1])
    );
  end

  assign carry_into_msb = carry[MSB];
  assign carry_out_msb  = carry[WIDTH];

  assign result_o = ctrl.valid ? cell_res : '0;
  assign zero_o   = ~|result_o;
  assign ovf_o    = ctrl.arith & (carry_into_msb ^ carry_out_msb);

  always_comb begin
    if (op_i == OP_ADD || op_i == OP_SUB) begin
      AST_ARITH_SUM: assert (result_o == sum_ref(opa_i, opb_i, op_i == OP_SUB)) else $error("sum mismatch"); // R3
    end
    if (op_i == OP_SLT) begin
      AST_SLT_UPPER: assert (result_o[MSB:1] == '0) else $error("compare upper bits set"); // R5
    end
    if (op_i == OP_ADD && (opa_i[MSB] != opb_i[MSB])) begin
      AST_NO_OVF_ADD: assert (!ovf_o) else $error("overflow on mixed-sign add"); // R8
    end
    if (op_i == OP_SUB && (opa_i[MSB] == opb_i[MSB])) begin
      AST_NO_OVF_SUB: assert (!ovf_o) else $error("overflow on same-sign sub"); // R8
    end
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT) begin
      AST_NO_OVF_LOGIC: assert (!ovf_o) else $error("overflow on non-arith op"); // R9
    end
    if (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_ADD || op_i == OP_SUB || op_i == OP_SLT)) begin
      AST_UNUSED_CODE: assert (result_o == '0 && !ovf_o && zero_o) else $error("unused code active"); // R10
    end
  end

endmodule

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] opa, opb;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero, ovf;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_alu i_bitslice_alu (
    .opa_i    (opa),
    .opb_i    (opb),
    .op_i     (op),
    .result_o (result),
    .zero_o   (zero),
    .ovf_o    (ovf)
  );

  function automatic logic [31:0] exp_result(input logic [3:0] c, input logic [31:0] a,
                                             input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    case (c)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return d;
      4'b0111: return {31'd0, d[31]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [3:0] c, input logic [31:0] a,
                                   input logic [31:0] b);
    longint s;
    if (c == 4'b0010) s = longint'($signed(a)) + longint'($signed(b));
    else if (c == 4'b0110) s = longint'($signed(a)) - longint'($signed(b));
    else return 1'b0;
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic string res_tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [3:0] c);
    case (c)
      4'b0010, 4'b0110: return "R7";
      4'b0000, 4'b0001, 4'b0111: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    @(negedge clk);
    op = c; opa = a; opb = b;
    #(CLK_PERIOD/4);
    er = exp_result(c, a, b);
    check(res_tag(c), result, er);
    check("R6", {31'd0, zero}, {31'd0, er == 32'd0});
    check(ovf_tag(c), {31'd0, ovf}, {31'd0, exp_ovf(c, a, b)});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [3:0] ops[5];
    ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111};
    op = 4'b0000; opa = '0; opb = '0;
    void'($urandom(32'd20240607));
    // reset-like idle state: AND of zeros, zero flag high (R1, R6)
    apply(4'b0000, 32'h0, 32'h0);
    // R1 / R2 directed
    apply(4'b0000, 32'hF0F0_1234, 32'hFF00_FF0F);
    apply(4'b0001, 32'h0F0F_0000, 32'h00F0_00A5);
    // R3 / R7 overflow edges
    apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
    apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
    // R4 / R7 overflow edges
    apply(4'b0110, 32'h8000_0000, 32'h0000_0001);
    apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678);
    // R8 cases: mixed-sign add, same-sign sub
    apply(4'b0010, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R8", {31'd0, ovf}, 32'd0);
    apply(4'b0110, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R8", {31'd0, ovf}, 32'd0);
    // R5 compare, including the raw-sign wrap case
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    check("R5", result, 32'h0000_0001);
    apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0001);
    apply(4'b0111, 32'h0000_0005, 32'h0000_0003);
    apply(4'b0111, 32'h0000_0003, 32'h0000_0003);
    // R10 unused codes
    for (int k = 0; k < 16; k++) begin
      apply(4'(k), 32'hDEAD_BEEF, 32'h8000_0001);
    end
    // constrained random over valid and unused codes
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  c;
      logic [31:0] a, b;
      c = ($urandom % 4 == 0) ? 4'($urandom) : ops[$urandom % 5];
      a = $urandom;
      b = $urandom;
      case ($urandom % 6)
        0: a = {a[31], 31'h7FFF_FFFF};
        1: b = {b[31], 31'd0};
        2: b = a;
        default: ;
      endcase
      apply(c, a, b);
    end
    summary();
  end

endmodule